// File: doc/BRIEF.md
# Sparse Section-Carry Prefix Network

This block takes one generate bit and one propagate bit per position of a wide operand and returns only the carries that enter the start of each fixed-length carry-select section: the carries into bit positions S, 2S, 3S and so on, where S is the section length. A downstream carry-select stage uses these carries to pick a precomputed sum for each section. The carry into bit 0 is always 1. The network adds it by placing an extra group below bit 0 that always generates and never propagates.

The lookahead tree is built in stages. Every cell in a stage combines either two or three groups, and a per-stage mask sets which. The first stage combines three groups and works directly on the per-bit signals. Each node reads its own group and the groups one and two spans below it, so no cell takes more than three inputs and no node drives more than three cells. The selected carries are captured in an output register, which is cleared by a synchronous active-low reset.

Top module: `sparse_carry_net`

## Requirements
- R1: Output bit k (k = 0 .. (WIDTH-1)/SECT - 1) equals the carry into operand bit (k+1)*SECT. That carry is formed by a bit-serial chain c = gen[i] | (prop[i] & c), which starts from a carry-in of 1 at bit 0.
- R2: When every propagate bit is 1 and every generate bit is 0, all output bits are 1, because the fixed carry-in reaches every section.
- R3: When every generate bit and every propagate bit is 0, all output bits are 0.
- R4: A generate bit of 1 at position (k+1)*SECT-1 forces output bit k to 1, whatever the lower bits are.
- R5: When every bit of section k+1 (positions (k+1)*SECT to (k+2)*SECT-1) has propagate 1 and generate 0, output bit k+1 equals output bit k.
- R6: The outputs reflect the inputs sampled at the previous rising clock edge (latency of one cycle). Between edges they hold steady.
- R7: At the first edge after a cycle with rst_n low, every output bit reads 0.
- R8: Generate 0 and propagate 0 together at position (k+1)*SECT-1 force output bit k to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| gen_i | input | WIDTH | Per-bit generate signals |
| prop_i | input | WIDTH | Per-bit propagate signals |
| sec_carry_o | output | (WIDTH-1)/SECT | Carries into bits SECT, 2*SECT, ... (bit 0 is the lowest section boundary) |

## Verification
Hand-worked vectors cover several cases: all-kill, all-propagate, all-generate, a single kill deep inside a propagate run, and single generates near the lowest and highest boundaries. Together these separate the effect of the fixed carry-in from carries generated at a position, and show whether a carry stops at the right section. A propagate run that spans three sections after a generate shows whether long-distance spans reach the correct boundary. Pseudo-random vectors, some with generate and propagate never both set and some with them set freely, are compared against a bit-serial chain in the bench. Mid-stream resets and a sample taken just before an edge show the reset behaviour and the one-cycle latency.

// File: rtl/spx_pkg.sv
// Package: shared group type and prefix operators for the sparse carry network.
// Assumes generate dominates when generate and propagate are both set.
package spx_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Identity group: neither generates nor blocks.
    localparam gp_t GP_IDENT = '{g: 1'b0, p: 1'b1};

    // Two-group operator: hi sits above lo.
    function automatic gp_t merge2(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Three-group operator in one step.
    function automatic gp_t merge3(gp_t hi, gp_t mid, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & mid.g) | (hi.p & mid.p & lo.g);
        r.p = hi.p & mid.p & lo.p;
        return r;
    endfunction

    // Radix of stage s: mask bit set selects three-input cells.
    function automatic int stage_radix(logic [31:0] mask, int s);
        return mask[s] ? 3 : 2;
    endfunction

    // Group span entering stage s (product of earlier radices).
    function automatic int span_before(logic [31:0] mask, int s);
        int acc;
        acc = 1;
        for (int i = 0; i < s; i++) acc = acc * stage_radix(mask, i);
        return acc;
    endfunction

endpackage

// File: rtl/spx_seed.sv
// Module: builds the extended group vector. Index 0 is the forced carry-in
// (always generates, never propagates); index i+1 holds operand bit i.
module spx_seed
    import spx_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    output gp_t  [WIDTH:0]   node_o
);
    // Carry-in slot.
    assign node_o[0] = '{g: 1'b1, p: 1'b0};

    // Operand bits shifted up by one slot.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign node_o[i+1] = '{g: gen_i[i], p: prop_i[i]};
    end
endmodule

// File: rtl/spx_stage.sv
// Module: one lookahead stage. Every cell uses the same radix. Cell i joins
// its own group with the groups DIST and 2*DIST below. Below index 0 the
// identity group is used, so a finished prefix passes through unchanged.
module spx_stage
    import spx_pkg::*;
#(
    parameter int NODES = 65,
    parameter int RADIX = 3,
    parameter int DIST  = 1
) (
    input  gp_t [NODES-1:0] in_i,
    output gp_t [NODES-1:0] out_o
);
    for (genvar i = 0; i < NODES; i++) begin : g_cell
        gp_t mid_w, lo_w;
        // Neighbour one span down, or identity past the bottom.
        if (i >= DIST) begin : g_mid
            assign mid_w = in_i[i-DIST];
        end else begin : g_mid_id
            assign mid_w = GP_IDENT;
        end
        // Neighbour two spans down (used by three-input cells only).
        if (RADIX == 3 && i >= 2*DIST) begin : g_lo
            assign lo_w = in_i[i-2*DIST];
        end else begin : g_lo_id
            assign lo_w = GP_IDENT;
        end
        // Cell operator chosen by the stage radix.
        if (RADIX == 3) begin : g_r3
            assign out_o[i] = merge3(in_i[i], mid_w, lo_w);
        end else begin : g_r2
            assign out_o[i] = merge2(in_i[i], mid_w);
        end
    end
endmodule

// File: rtl/spx_tap.sv
// Module: picks the sparse carries out of the final prefix vector. Extended
// index m covers operand bits m-1 down to the carry-in, so its generate is
// the carry into operand bit m.
module spx_tap
    import spx_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int SECT  = 6,
    parameter int NC    = 10
) (
    input  gp_t  [WIDTH:0] pfx_i,
    output logic [NC-1:0]  carry_o
);
    for (genvar k = 0; k < NC; k++) begin : g_tap
        assign carry_o[k] = pfx_i[(k+1)*SECT].g;
    end
endmodule

// File: rtl/sparse_carry_net.sv
// Module: top of the sparse section-carry network. Seeds the group vector,
// runs NSTAGE lookahead stages whose radix comes from RADIX3_MASK, taps the
// section-boundary carries and registers them.
// Assumes the product of the stage radices is at least WIDTH+1, so the
// last stage holds complete prefixes.
module sparse_carry_net
    import spx_pkg::*;
#(
    parameter int          WIDTH       = 64,
    parameter int          SECT        = 6,
    parameter int          NSTAGE      = 5,
    parameter logic [31:0] RADIX3_MASK = 32'h0000_0011,
    localparam int         NC          = (WIDTH - 1) / SECT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    output logic [NC-1:0]    sec_carry_o
);
    localparam int NODES = WIDTH + 1;

    gp_t [NODES-1:0] lvl [NSTAGE+1];
    logic [NC-1:0]   carry_w;

    spx_seed #(.WIDTH(WIDTH)) u_seed (
        .gen_i  (gen_i),
        .prop_i (prop_i),
        .node_o (lvl[0])
    );

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        spx_stage #(
            .NODES (NODES),
            .RADIX (stage_radix(RADIX3_MASK, s)),
            .DIST  (span_before(RADIX3_MASK, s))
        ) u_stage (
            .in_i  (lvl[s]),
            .out_o (lvl[s+1])
        );
    end

    spx_tap #(.WIDTH(WIDTH), .SECT(SECT), .NC(NC)) u_tap (
        .pfx_i   (lvl[NSTAGE]),
        .carry_o (carry_w)
    );

    // Output register: clear on reset, else capture the selected carries.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_carry_o <= '0;
        else        sec_carry_o <= carry_w;
    end
endmodule

// File: rtl/spx_chk.sv
// Checker: compares the registered carries with a bit-serial chain and
// checks the local boundary rules. Attached to the top with bind.
module spx_chk #(
    parameter int WIDTH = 64,
    parameter int SECT  = 6,
    parameter int NC    = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] gen_i,
    input logic [WIDTH-1:0] prop_i,
    input logic [NC-1:0]    sec_carry_o
);
    logic [NC-1:0] ripple_c;
    logic [NC-1:0] sect_pass;

    // Serial reference chain from a carry-in of 1.
    always_comb begin
        logic c;
        c = 1'b1;
        ripple_c = '0;
        for (int i = 0; i < WIDTH; i++) begin
            c = gen_i[i] | (prop_i[i] & c);
            if (((i + 1) % SECT == 0) && ((i + 1) / SECT <= NC))
                ripple_c[(i+1)/SECT - 1] = c;
        end
    end

    // Per section: every bit propagates and none generates.
    always_comb begin
        for (int k = 0; k < NC; k++)
            sect_pass[k] = (&prop_i[k*SECT +: SECT]) && (gen_i[k*SECT +: SECT] == '0);
    end

    // R1 and R6: registered carries match the serial chain one cycle later.
    assert_ripple_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sec_carry_o == $past(ripple_c));

    assert_cin_reaches_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&prop_i && gen_i == '0) |=> &sec_carry_o);

    assert_no_phantom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_i == '0 && prop_i == '0) |=> sec_carry_o == '0);

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> sec_carry_o == '0);

    for (genvar k = 0; k < NC; k++) begin : g_bound
        assert_gen_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gen_i[(k+1)*SECT-1] |=> sec_carry_o[k]);
        assert_kill_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!gen_i[(k+1)*SECT-1] && !prop_i[(k+1)*SECT-1]) |=> !sec_carry_o[k]);
    end

    for (genvar k = 0; k + 1 < NC; k++) begin : g_pass
        assert_sect_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sect_pass[k+1] |=> sec_carry_o[k+1] == sec_carry_o[k]);
    end
endmodule

bind sparse_carry_net spx_chk #(.WIDTH(WIDTH), .SECT(SECT), .NC(NC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_i       (gen_i),
    .prop_i      (prop_i),
    .sec_carry_o (sec_carry_o)
);

// File: tb/sim_sparse_carry_net.sv
// Bench: table of hand-worked vectors, pseudo-random vectors against a
// serial chain, then directed reset and latency tests.
module sim_sparse_carry_net;
    localparam int WIDTH = 64;
    localparam int SECT  = 6;
    localparam int NC    = (WIDTH - 1) / SECT;
    localparam int NVEC  = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] gen_i = '0;
    logic [WIDTH-1:0] prop_i = '0;
    logic [NC-1:0]    sec_carry_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sparse_carry_net u0 (
        .clk(clk), .rst_n(rst_n), .gen_i(gen_i), .prop_i(prop_i),
        .sec_carry_o(sec_carry_o)
    );

    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
    // Rows: {gen, prop, expected carries}.
    localparam logic [WIDTH-1:0] T_GEN [NVEC] = '{
        64'h0, 64'h0, ONES, 64'h0, 64'h20,
        64'h20, 64'h0800_0000_0000_0000, 64'h2000_0000, 64'h0};
    localparam logic [WIDTH-1:0] T_PROP [NVEC] = '{
        64'h0, ONES, 64'h0, ONES & ~64'h1, 64'h0,
        64'hFFFF_FFFF_FFFF_FFC0, 64'h0, 64'h0000_03FF_C000_0000,
        ONES & ~64'h8_0000_0000};
    localparam logic [NC-1:0] T_EXP [NVEC] = '{
        10'h000, 10'h3FF, 10'h3FF, 10'h000, 10'h001,
        10'h3FF, 10'h200, 10'h070, 10'h01F};

    function automatic string row_tag(int i);
        case (i)
            0: return "R3 all kill";
            1: return "R2 all propagate";
            2: return "R4 all generate";
            3: return "R8 carry-in killed at bit 0";
            4: return "R4 generate below first boundary";
            5: return "R5 generate then full propagate";
            6: return "R4 generate below last boundary";
            7: return "R5 run across three sections";
            default: return "R1 kill inside propagate run";
        endcase
    endfunction

    function automatic logic [NC-1:0] serial_ref(logic [WIDTH-1:0] g, logic [WIDTH-1:0] p);
        logic [NC-1:0] r;
        logic c;
        c = 1'b1;
        r = '0;
        for (int i = 0; i < WIDTH; i++) begin
            c = g[i] | (p[i] & c);
            if ((i + 1) % SECT == 0 && (i + 1) / SECT <= NC) r[(i+1)/SECT - 1] = c;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply(logic [WIDTH-1:0] g, logic [WIDTH-1:0] p);
        @(negedge clk);
        gen_i  = g;
        prop_i = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    logic [31:0] lfsr = 32'hACE1_2357;
    function automatic logic [31:0] step(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] g, p;
        // R7: output is zero under reset even with active inputs.
        gen_i = ONES;
        prop_i = ONES;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 held in reset", sec_carry_o, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(T_GEN[i], T_PROP[i]);
            check(row_tag(i), sec_carry_o, T_EXP[i]);
        end

        // R1: random, generate and propagate mutually exclusive.
        for (int n = 0; n < 60; n++) begin
            lfsr = step(lfsr); g[31:0] = lfsr;  lfsr = step(lfsr); g[63:32] = lfsr;
            lfsr = step(lfsr); p[31:0] = lfsr;  lfsr = step(lfsr); p[63:32] = lfsr;
            p = p | (p << 1) | (p << 2);
            g = g & ~p & (g >> 1);
            apply(g, p);
            check("R1 random exclusive", sec_carry_o, serial_ref(g, p));
        end
        // R1: random, free combinations.
        for (int n = 0; n < 40; n++) begin
            lfsr = step(lfsr); g[31:0] = lfsr;  lfsr = step(lfsr); g[63:32] = lfsr;
            lfsr = step(lfsr); p[31:0] = lfsr;  lfsr = step(lfsr); p[63:32] = lfsr;
            apply(g, p);
            check("R1 random free", sec_carry_o, serial_ref(g, p));
        end

        // R6: new inputs do not show before the next rising edge.
        apply(64'h0, ONES);
        @(negedge clk);
        gen_i  = 64'h0;
        prop_i = 64'h0;
        #3;
        check("R6 held before edge", sec_carry_o, 10'h3FF);
        @(posedge clk);
        @(negedge clk);
        check("R6 updated after edge", sec_carry_o, 10'h000);

        // R7: mid-stream reset clears, release resumes.
        apply(ONES, 64'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 mid-stream reset", sec_carry_o, '0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 resume after reset", sec_carry_o, 10'h3FF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule